// File: doc/BRIEF.md
# Byte-wide Host Port Bridge

This block is a slave port that gives an external host access to a 16-bit on-chip shared memory over an 8-bit parallel bus. The host moves every 16-bit value as two byte cycles in a row. A byte-select input marks each cycle as the first or the second half of the pair. A 2-bit register select input picks one of three targets: the control register, the address register, or the data path. The data path comes in two flavours, with and without address auto-increment.

Host byte cycles arrive as single-cycle strobes that are already synchronous to the block clock. A data write holds the first byte and issues one 16-bit memory write when the second byte arrives. A data read fetches the word on the first byte, returns its first half one cycle later, and serves the second half from a latched copy. The local processor shares the same memory port and can read and write the control register. When both sides want the memory in the same cycle, the host takes it and the local processor's grant is withheld for that cycle.

Top module: `hpb_bridge`

## Requirements
- R1: After reset the address register reads 0 and the control register is 0, so the first byte is the most significant half. No memory request, no host response and no local grant is active.
- R2: Register select codes: 00 is control, 01 is data with increment, 10 is address, 11 is data without increment. A host data write issues no host memory request on its first byte. It issues one memory write in the cycle of the second byte strobe, with the word assembled from the two bytes.
- R3: Control bit 0 is the byte order: 0 means the first byte is bits 15:8, and 1 means the first byte is bits 7:0. The bit is mirrored at bit 8 and all other bits read 0. A host control byte write sets the order from bit 0 of the byte.
- R4: The local processor writes the order from bit 0 of its control write data and reads the full 16-bit control register. If the host writes control in the same cycle, the host value is kept.
- R5: An address write is two bytes placed by the byte order. The address register is unchanged after the first byte and loads after the second byte. Host reads of the address register return it zero-extended to 16 bits.
- R6: Every host read strobe gives host_rvalid_o high for exactly the next cycle, with the byte on host_rdata_o. A data read fetches the word at the first byte. The second byte comes from a copy latched at that fetch, so a local write to the same word between the two bytes does not change it.
- R7: Select 01 increments the address after the second byte of a data read or write, wrapping at 2^AW. Select 11 leaves the address unchanged.
- R8: In a cycle with a host memory access, the memory port carries the host access and lp_gnt_o is low. Otherwise lp_gnt_o equals lp_req_i and the port carries the local access.
- R9: A granted local read returns mem_rdata_i on lp_rdata_o with lp_rvalid_o high in the next cycle.
- R10: A second byte without a preceding first byte uses whatever the holding register contains. The next correctly ordered pair then behaves normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_strb_i | input | 1 | One-cycle host byte strobe |
| host_wr_i | input | 1 | 1 = host byte write, 0 = read |
| host_sel_i | input | 2 | Register select (00 ctl, 01 data+inc, 10 addr, 11 data) |
| host_second_i | input | 1 | 0 = first byte, 1 = second byte |
| host_wdata_i | input | 8 | Host write byte |
| host_rvalid_o | output | 1 | Host read byte valid |
| host_rdata_o | output | 8 | Host read byte |
| lp_req_i | input | 1 | Local memory request |
| lp_we_i | input | 1 | Local write enable |
| lp_addr_i | input | AW | Local word address |
| lp_wdata_i | input | 16 | Local write word |
| lp_gnt_o | output | 1 | Local request granted this cycle |
| lp_rvalid_o | output | 1 | Local read data valid |
| lp_rdata_o | output | 16 | Local read word |
| lp_ctl_we_i | input | 1 | Local control register write |
| lp_ctl_wdata_i | input | 16 | Local control write value |
| lp_ctl_o | output | 16 | Control register value |
| mem_req_o | output | 1 | Memory access enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | 16 | Memory write word |
| mem_rdata_i | input | 16 | Memory read word, one cycle after request |

## Verification
The assertions assume that host strobes are already synchronous and last one cycle each. They also assume the memory returns read data exactly one cycle after a request, and that the local processor keeps its request asserted until granted. The bench drives every input on the falling edge and models the memory as a one-cycle synchronous array. It holds lp_req_i across the host-priority cycle until the grant appears. Broken byte sequences are produced on purpose only in the recovery test, and the data they write is never compared.

// File: rtl/hpb_pkg.sv
package hpb_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    SEL_CTL      = 2'b00,
    SEL_DATA_INC = 2'b01,
    SEL_ADDR     = 2'b10,
    SEL_DATA     = 2'b11
  } host_sel_e;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'b00,
    SRC_REG   = 2'b01,
    SRC_MEM   = 2'b10,
    SRC_LATCH = 2'b11
  } rsp_src_e;

  function automatic logic [WORD_W-1:0] join_bytes(input logic [BYTE_W-1:0] first_b,
                                                   input logic [BYTE_W-1:0] second_b,
                                                   input logic lsb_first);
    return lsb_first ? {second_b, first_b} : {first_b, second_b};
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] w,
                                                  input logic is_second,
                                                  input logic lsb_first);
    return (is_second ^ lsb_first) ? w[BYTE_W-1:0] : w[WORD_W-1:BYTE_W];
  endfunction
endpackage

// File: rtl/hpb_regs.sv
module hpb_regs
  import hpb_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strb_i,
  input  logic              wr_i,
  input  host_sel_e         sel_i,
  input  logic              second_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              lp_ctl_we_i,
  input  logic [WORD_W-1:0] lp_ctl_wdata_i,
  output logic              order_o,
  output logic [WORD_W-1:0] ctl_o,
  output logic [AW-1:0]     addr_o,
  output logic [BYTE_W-1:0] hold_o
);
  localparam int PAD_W = BYTE_W - 1;

  logic              order_q;
  logic [AW-1:0]     addr_q;
  logic [BYTE_W-1:0] hold_q;
  logic              host_wr;
  logic [WORD_W-1:0] new_word;

  assign host_wr  = strb_i & wr_i;
  assign new_word = join_bytes(hold_q, wdata_i, order_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      order_q <= 1'b0;
    end else if (host_wr && sel_i == SEL_CTL) begin
      order_q <= wdata_i[0];  // host wins over local write
    end else if (lp_ctl_we_i) begin
      order_q <= lp_ctl_wdata_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
    end else if (host_wr && !second_i && sel_i != SEL_CTL) begin
      hold_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (host_wr && second_i && sel_i == SEL_ADDR) begin
      addr_q <= new_word[AW-1:0];
    end else if (strb_i && second_i && sel_i == SEL_DATA_INC) begin
      addr_q <= addr_q + AW'(1);
    end
  end

  assign order_o = order_q;
  assign ctl_o   = {{PAD_W{1'b0}}, order_q, {PAD_W{1'b0}}, order_q};
  assign addr_o  = addr_q;
  assign hold_o  = hold_q;

  p_addr_first_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_i && wr_i && sel_i == SEL_ADDR && !second_i) |=> $stable(addr_o));

  p_plain_data_keeps_addr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_i && sel_i == SEL_DATA) |=> $stable(addr_o));
endmodule

// File: rtl/hpb_arb.sv
module hpb_arb
  import hpb_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_req_i,
  input  logic              host_we_i,
  input  logic [AW-1:0]     host_addr_i,
  input  logic [WORD_W-1:0] host_wdata_i,
  input  logic              lp_req_i,
  input  logic              lp_we_i,
  input  logic [AW-1:0]     lp_addr_i,
  input  logic [WORD_W-1:0] lp_wdata_i,
  output logic              lp_gnt_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o
);
  always_comb begin
    lp_gnt_o  = lp_req_i & ~host_req_i;
    mem_req_o = host_req_i | lp_req_i;
    if (host_req_i) begin
      mem_we_o    = host_we_i;
      mem_addr_o  = host_addr_i;
      mem_wdata_o = host_wdata_i;
    end else begin
      mem_we_o    = lp_we_i & lp_req_i;
      mem_addr_o  = lp_addr_i;
      mem_wdata_o = lp_wdata_i;
    end
  end

  p_host_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_req_i |-> (!lp_gnt_o && mem_req_o && mem_addr_o == host_addr_i));

  p_lp_served_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_req_i && !host_req_i) |-> (lp_gnt_o && mem_addr_o == lp_addr_i));
endmodule

// File: rtl/hpb_rsp.sv
module hpb_rsp
  import hpb_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strb_i,
  input  logic              wr_i,
  input  host_sel_e         sel_i,
  input  logic              second_i,
  input  logic              order_i,
  input  logic [WORD_W-1:0] ctl_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              rvalid_o,
  output logic [BYTE_W-1:0] rdata_o
);
  rsp_src_e          src_q;
  logic              second_q;
  logic              order_q;
  logic [BYTE_W-1:0] reg_byte_q;
  logic [WORD_W-1:0] word_q;
  logic              host_rd;
  logic [WORD_W-1:0] reg_word;

  assign host_rd  = strb_i & ~wr_i;
  assign reg_word = (sel_i == SEL_CTL) ? ctl_i : WORD_W'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q      <= SRC_NONE;
      second_q   <= 1'b0;
      order_q    <= 1'b0;
      reg_byte_q <= '0;
    end else begin
      src_q <= SRC_NONE;
      if (host_rd) begin
        second_q   <= second_i;
        order_q    <= order_i;
        reg_byte_q <= pick_byte(reg_word, second_i, order_i);
        if (sel_i == SEL_DATA || sel_i == SEL_DATA_INC) begin
          src_q <= second_i ? SRC_LATCH : SRC_MEM;
        end else begin
          src_q <= SRC_REG;
        end
      end
    end
  end

  // copy of the fetched word serves the second byte
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
    end else if (src_q == SRC_MEM) begin
      word_q <= mem_rdata_i;
    end
  end

  always_comb begin
    unique case (src_q)
      SRC_REG:   rdata_o = reg_byte_q;
      SRC_MEM:   rdata_o = pick_byte(mem_rdata_i, second_q, order_q);
      SRC_LATCH: rdata_o = pick_byte(word_q, 1'b1, order_q);
      default:   rdata_o = '0;
    endcase
  end

  assign rvalid_o = (src_q != SRC_NONE);

  p_rsp_next_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_i && !wr_i) |=> rvalid_o);

  p_rsp_only_reads_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(strb_i && !wr_i) |=> !rvalid_o);
endmodule

// File: rtl/hpb_bridge.sv
module hpb_bridge
  import hpb_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                host_strb_i,
  input  logic                host_wr_i,
  input  logic [1:0]          host_sel_i,
  input  logic                host_second_i,
  input  logic [BYTE_W-1:0]   host_wdata_i,
  output logic                host_rvalid_o,
  output logic [BYTE_W-1:0]   host_rdata_o,
  input  logic                lp_req_i,
  input  logic                lp_we_i,
  input  logic [AW-1:0]       lp_addr_i,
  input  logic [WORD_W-1:0]   lp_wdata_i,
  output logic                lp_gnt_o,
  output logic                lp_rvalid_o,
  output logic [WORD_W-1:0]   lp_rdata_o,
  input  logic                lp_ctl_we_i,
  input  logic [WORD_W-1:0]   lp_ctl_wdata_i,
  output logic [WORD_W-1:0]   lp_ctl_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [AW-1:0]       mem_addr_o,
  output logic [WORD_W-1:0]   mem_wdata_o,
  input  logic [WORD_W-1:0]   mem_rdata_i
);
  host_sel_e         sel;
  logic              order;
  logic [WORD_W-1:0] ctl;
  logic [AW-1:0]     addr;
  logic [BYTE_W-1:0] hold;
  logic              host_req;
  logic [WORD_W-1:0] host_wword;
  logic              lp_rvalid_q;

  assign sel = host_sel_e'(host_sel_i);

  // write: memory on second byte; read: memory on first byte
  assign host_req   = host_strb_i & host_sel_i[0] & (host_wr_i ? host_second_i : ~host_second_i);
  assign host_wword = join_bytes(hold, host_wdata_i, order);

  hpb_regs #(.AW(AW)) u_regs (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .strb_i         (host_strb_i),
    .wr_i           (host_wr_i),
    .sel_i          (sel),
    .second_i       (host_second_i),
    .wdata_i        (host_wdata_i),
    .lp_ctl_we_i    (lp_ctl_we_i),
    .lp_ctl_wdata_i (lp_ctl_wdata_i),
    .order_o        (order),
    .ctl_o          (ctl),
    .addr_o         (addr),
    .hold_o         (hold)
  );

  hpb_arb #(.AW(AW)) u_arb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_req_i   (host_req),
    .host_we_i    (host_wr_i),
    .host_addr_i  (addr),
    .host_wdata_i (host_wword),
    .lp_req_i     (lp_req_i),
    .lp_we_i      (lp_we_i),
    .lp_addr_i    (lp_addr_i),
    .lp_wdata_i   (lp_wdata_i),
    .lp_gnt_o     (lp_gnt_o),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o)
  );

  hpb_rsp #(.AW(AW)) u_rsp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strb_i      (host_strb_i),
    .wr_i        (host_wr_i),
    .sel_i       (sel),
    .second_i    (host_second_i),
    .order_i     (order),
    .ctl_i       (ctl),
    .addr_i      (addr),
    .mem_rdata_i (mem_rdata_i),
    .rvalid_o    (host_rvalid_o),
    .rdata_o     (host_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lp_rvalid_q <= 1'b0;
    else         lp_rvalid_q <= lp_gnt_o & ~lp_we_i;
  end

  assign lp_rvalid_o = lp_rvalid_q;
  assign lp_rdata_o  = mem_rdata_i;
  assign lp_ctl_o    = ctl;

  p_first_write_no_mem_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_strb_i && host_wr_i && host_sel_i[0] && !host_second_i) |-> (!mem_req_o || lp_gnt_o));

  p_lp_read_rsp_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_gnt_o && !lp_we_i) |=> lp_rvalid_o);
endmodule

// File: tb/hpb_bridge_bench.sv
module hpb_bridge_bench;
  localparam int AW = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_ni;
  logic        host_strb, host_wr, host_second;
  logic [1:0]  host_sel;
  logic [7:0]  host_wdata;
  logic        host_rvalid_o;
  logic [7:0]  host_rdata_o;
  logic        lp_req, lp_we;
  logic [AW-1:0] lp_addr;
  logic [15:0] lp_wdata;
  logic        lp_gnt_o, lp_rvalid_o;
  logic [15:0] lp_rdata_o;
  logic        lp_ctl_we;
  logic [15:0] lp_ctl_wdata, lp_ctl_o;
  logic        mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [15:0] mem_wdata_o, ram_rdata;

  hpb_bridge #(.AW(AW)) u_hpb_bridge (
    .clk_i(clk), .rst_ni(rst_ni),
    .host_strb_i(host_strb), .host_wr_i(host_wr), .host_sel_i(host_sel),
    .host_second_i(host_second), .host_wdata_i(host_wdata),
    .host_rvalid_o(host_rvalid_o), .host_rdata_o(host_rdata_o),
    .lp_req_i(lp_req), .lp_we_i(lp_we), .lp_addr_i(lp_addr), .lp_wdata_i(lp_wdata),
    .lp_gnt_o(lp_gnt_o), .lp_rvalid_o(lp_rvalid_o), .lp_rdata_o(lp_rdata_o),
    .lp_ctl_we_i(lp_ctl_we), .lp_ctl_wdata_i(lp_ctl_wdata), .lp_ctl_o(lp_ctl_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(ram_rdata)
  );

  logic [15:0] ram [0:(1<<AW)-1];
  initial for (int i = 0; i < (1 << AW); i++) ram[i] = 16'h0000;
  always @(posedge clk) begin
    if (mem_req_o) begin
      if (mem_we_o) ram[mem_addr_o] <= mem_wdata_o;
      ram_rdata <= ram[mem_addr_o];
    end
  end

  int    n_chk = 0;
  int    n_bad = 0;
  bit    lsb_first = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni && host_rvalid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected host response", {24'h0, host_rdata_o}, 32'hffff_ffff);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(host_rdata_o == e, t, {24'h0, host_rdata_o}, {24'h0, e});
      end
    end
  end

  function automatic logic [7:0] first_of(input logic [15:0] w);
    return lsb_first ? w[7:0] : w[15:8];
  endfunction
  function automatic logic [7:0] second_of(input logic [15:0] w);
    return lsb_first ? w[15:8] : w[7:0];
  endfunction

  task automatic host_byte(input bit wr, input logic [1:0] sel, input bit second, input logic [7:0] d);
    host_strb = 1'b1; host_wr = wr; host_sel = sel; host_second = second; host_wdata = d;
    @(negedge clk);
    host_strb = 1'b0;
  endtask

  task automatic host_wr_word(input logic [1:0] sel, input logic [15:0] w);
    host_strb = 1'b1; host_wr = 1'b1; host_sel = sel; host_second = 1'b0; host_wdata = first_of(w);
    #1;
    if (sel[0]) check(!mem_req_o, "R2 no memory access on first byte", {31'h0, mem_req_o}, 32'h0);
    @(negedge clk);
    host_second = 1'b1; host_wdata = second_of(w);
    #1;
    if (sel[0]) check(mem_req_o && mem_we_o, "R2 memory write on second byte",
                      {30'h0, mem_req_o, mem_we_o}, 32'h3);
    @(negedge clk);
    host_strb = 1'b0;
  endtask

  task automatic host_rd_word(input logic [1:0] sel, input logic [15:0] w, input string tag);
    exp_q.push_back(first_of(w));  tag_q.push_back(tag);
    exp_q.push_back(second_of(w)); tag_q.push_back(tag);
    host_byte(1'b0, sel, 1'b0, 8'h00);
    host_byte(1'b0, sel, 1'b1, 8'h00);
  endtask

  task automatic set_addr(input logic [15:0] a);
    host_wr_word(2'b10, a);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; host_strb = 0; host_wr = 0; host_sel = 0; host_second = 0; host_wdata = 0;
    lp_req = 0; lp_we = 0; lp_addr = '0; lp_wdata = 0; lp_ctl_we = 0; lp_ctl_wdata = 0;
    repeat (3) @(negedge clk);
    #1;
    check(!mem_req_o && !host_rvalid_o && !lp_gnt_o, "R1 outputs idle in reset",
          {29'h0, mem_req_o, host_rvalid_o, lp_gnt_o}, 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    check(lp_ctl_o == 16'h0000, "R1 control reset", {16'h0, lp_ctl_o}, 32'h0);
    check(!mem_req_o && !host_rvalid_o, "R1 idle after reset", {30'h0, mem_req_o, host_rvalid_o}, 32'h0);
    @(negedge clk);
    host_rd_word(2'b10, 16'h0000, "R1 address reset");

    // address and plain data path, MSB first
    set_addr(16'h0123);
    host_rd_word(2'b10, 16'h0123, "R5 address loaded");
    host_wr_word(2'b11, 16'hA55A);
    check(ram[10'h123] == 16'hA55A, "R2 write MSB first", {16'h0, ram[10'h123]}, 32'hA55A);
    host_rd_word(2'b10, 16'h0123, "R7 no increment on select 11");
    host_rd_word(2'b11, 16'hA55A, "R6 data read MSB first");

    // byte order via host control write
    host_byte(1'b1, 2'b00, 1'b0, 8'h01);
    host_byte(1'b1, 2'b00, 1'b1, 8'h01);
    lsb_first = 1'b1;
    check(lp_ctl_o == 16'h0101, "R3 order bit mirrored", {16'h0, lp_ctl_o}, 32'h0101);
    host_rd_word(2'b00, 16'h0101, "R3 host control read");

    // auto-increment, LSB first
    host_wr_word(2'b01, 16'h1234);
    check(ram[10'h123] == 16'h1234, "R2 write LSB first", {16'h0, ram[10'h123]}, 32'h1234);
    host_wr_word(2'b01, 16'hBEEF);
    check(ram[10'h124] == 16'hBEEF, "R7 write at incremented address", {16'h0, ram[10'h124]}, 32'hBEEF);
    host_rd_word(2'b10, 16'h0125, "R7 address after two writes");
    set_addr(16'h0123);
    host_rd_word(2'b01, 16'h1234, "R6 read LSB first");
    host_rd_word(2'b01, 16'hBEEF, "R7 read at incremented address");
    host_rd_word(2'b10, 16'h0125, "R7 address after two reads");

    // wrap
    set_addr(16'h03FF);
    host_wr_word(2'b01, 16'h5A5A);
    check(ram[10'h3FF] == 16'h5A5A, "R7 write at top address", {16'h0, ram[10'h3FF]}, 32'h5A5A);
    host_rd_word(2'b10, 16'h0000, "R7 address wraps");

    // local control access
    lp_ctl_we = 1'b1; lp_ctl_wdata = 16'h0000;
    @(negedge clk);
    lp_ctl_we = 1'b0;
    lsb_first = 1'b0;
    check(lp_ctl_o == 16'h0000, "R4 local control write", {16'h0, lp_ctl_o}, 32'h0);
    lp_ctl_we = 1'b1; lp_ctl_wdata = 16'h0000;
    host_byte(1'b1, 2'b00, 1'b0, 8'h01);
    lp_ctl_we = 1'b0;
    check(lp_ctl_o == 16'h0101, "R4 host wins same-cycle control write", {16'h0, lp_ctl_o}, 32'h0101);
    lp_ctl_we = 1'b1; lp_ctl_wdata = 16'hFFFE;
    @(negedge clk);
    lp_ctl_we = 1'b0;
    check(lp_ctl_o == 16'h0000, "R4 local write uses bit 0", {16'h0, lp_ctl_o}, 32'h0);
    host_rd_word(2'b00, 16'h0000, "R4 host sees local control value");

    // tear-free second byte
    set_addr(16'h0010);
    host_wr_word(2'b11, 16'h1111);
    exp_q.push_back(8'h11); tag_q.push_back("R6 first byte before local write");
    host_byte(1'b0, 2'b11, 1'b0, 8'h00);
    lp_req = 1'b1; lp_we = 1'b1; lp_addr = 10'h010; lp_wdata = 16'h2222;
    @(negedge clk);
    lp_req = 1'b0; lp_we = 1'b0;
    exp_q.push_back(8'h11); tag_q.push_back("R6 second byte from latched copy");
    host_byte(1'b0, 2'b11, 1'b1, 8'h00);
    host_rd_word(2'b11, 16'h2222, "R6 local write landed");

    // arbitration
    set_addr(16'h0020);
    host_byte(1'b1, 2'b11, 1'b0, 8'hCA);
    host_strb = 1'b1; host_wr = 1'b1; host_sel = 2'b11; host_second = 1'b1; host_wdata = 8'hFE;
    lp_req = 1'b1; lp_we = 1'b0; lp_addr = 10'h123;
    #1;
    check(!lp_gnt_o, "R8 local stalled during host access", {31'h0, lp_gnt_o}, 32'h0);
    check(mem_addr_o == 10'h020, "R8 host address on memory port", {22'h0, mem_addr_o}, 32'h020);
    @(negedge clk);
    host_strb = 1'b0;
    #1;
    check(lp_gnt_o && mem_addr_o == 10'h123, "R8 local granted next cycle",
          {21'h0, lp_gnt_o, mem_addr_o}, {21'h1, 10'h123});
    @(negedge clk);
    lp_req = 1'b0;
    #1;
    check(lp_rvalid_o && lp_rdata_o == 16'h1234, "R9 local read data",
          {15'h0, lp_rvalid_o, lp_rdata_o}, {15'h0, 1'b1, 16'h1234});
    check(ram[10'h020] == 16'hCAFE, "R8 host write completed", {16'h0, ram[10'h020]}, 32'hCAFE);
    @(negedge clk);
    #1;
    check(!lp_rvalid_o, "R9 single-cycle local response", {31'h0, lp_rvalid_o}, 32'h0);
    @(negedge clk);

    // recovery after broken sequences
    set_addr(16'h0030);
    host_byte(1'b1, 2'b11, 1'b1, 8'h77);
    host_wr_word(2'b11, 16'h4321);
    check(ram[10'h030] == 16'h4321, "R10 pair after lone second byte", {16'h0, ram[10'h030]}, 32'h4321);
    exp_q.push_back(8'h43); tag_q.push_back("R10 repeated first byte");
    host_byte(1'b0, 2'b11, 1'b0, 8'h00);
    exp_q.push_back(8'h43); tag_q.push_back("R10 repeated first byte");
    host_byte(1'b0, 2'b11, 1'b0, 8'h00);
    host_rd_word(2'b11, 16'h4321, "R10 read after broken sequence");
    host_rd_word(2'b10, 16'h0030, "R10 address intact");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R6 all host reads answered", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule